// File: doc/BRIEF.md
# Pin Function Multiplexer and GPIO Register Block

This block controls 54 general-purpose pins through a small 32-bit register bus. Each pin has a 3-bit function code. The code makes the pin a plain input, a software-driven output, or one of six alternate peripheral functions. In output mode the pin is driven from a per-pin output latch. Software never writes that latch directly. It changes the latch through write-one-to-set and write-one-to-clear registers, so one write can change any group of pins without a read-modify-write.

Pad levels pass through a two-flop synchronizer. The synchronized levels can be read in every function mode. For each pin, the level is also passed to the alternate-function input bus of whichever alternate function that pin selects. Pull resistors are programmed in two steps. First a shared 2-bit pull code is written. Then a per-pin strobe bit is raised, and while the strobe is high the pin's pull state copies the shared code. After the strobe is lowered, the pin keeps its state even if the shared code changes.

The bus uses word addresses and has no handshake: a write takes effect at the clock edge where the write strobe is high. Read data is returned one cycle after the read strobe. Reset is synchronous and active low.

Top module: `gpio_mux_ctrl`

## Requirements
- R1: After reset, every pin is in input mode with pad_oe low, every output latch is 0, every pull_state field is 00, every select register reads 0 and bus_rdata is 0.
- R2: Select register n is at byte offset 4*n, for n = 0 to 5. Pin p owns bits 3*(p%10)+2 : 3*(p%10) of select register p/10. A written field reads back unchanged.
- R3: Function code 000 sets pad_oe low for the pin. Code 001 sets pad_oe high and drives pad_out from the pin's output latch.
- R4: The alternate codes map as follows: 100 is alternate 0, 101 is alternate 1, 110 is alternate 2, 111 is alternate 3, 011 is alternate 4 and 010 is alternate 5. For pin p in alternate k, pad_oe and pad_out come from alt_oe and alt_out at bit k*54+p. alt_in at bit k*54+p carries the pin's synchronized level when pin p selects alternate k, and is 0 otherwise.
- R5: Set registers are at 0x1C (pins 0-31) and 0x20 (pins 32-53, pin p at bit p%32). Each 1 bit sets that pin's output latch and each 0 bit leaves it unchanged. The latch keeps its value in every function mode.
- R6: Clear registers are at 0x28 and 0x2C, with the same bit layout as the set registers. Each 1 bit clears that pin's latch and each 0 bit leaves it unchanged.
- R7: Level registers are at 0x34 and 0x38, with the same bit layout. They return pad_in after two synchronizer flops in every function mode. After pad_in changes, the first two back-to-back reads still return the old level and the third returns the new level.
- R8: The pull code register at 0x94 stores wdata bits 1:0 (00 none, 01 pull-down, 10 pull-up) and reads them back with all higher bits 0.
- R9: Pull strobe registers are at 0x98 and 0x9C, with the same bit layout. pull_state bits 2p+1:2p take the pull code value from every clock edge at which pin p's stored strobe bit is 1, and hold their value while that bit is 0.
- R10: Reads of the set, clear and pull-strobe registers, of unmapped offsets, of select bits 31:30, and of select fields for pins above 53 all return 0.
- R11: Bits 31:22 of the second set, clear, level and pull-strobe registers (pins 54 to 63) are ignored on write and read as 0.
- R12: bus_rdata is updated one cycle after bus_rd_en is high, and is 0 in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register (bits 1:0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd_en |
| pad_in | input | 54 | Pad input levels (asynchronous) |
| pad_oe | output | 54 | Per-pin output enable |
| pad_out | output | 54 | Per-pin output data |
| pull_state | output | 108 | Latched 2-bit pull code per pin (pin p at 2p+1:2p) |
| alt_oe | input | 324 | Output enable from the alternate functions, bit k*54+p |
| alt_out | input | 324 | Output data from the alternate functions, bit k*54+p |
| alt_in | output | 324 | Synchronized pin level to the alternate functions, bit k*54+p |

## Verification
The assertions check on every cycle that input mode never drives a pin and that output mode drives the latch value. They also check that the level is exactly the pad value from two edges earlier, that pull states move only on a cycle after a raised strobe and then take the pull code, and that write-only and unmapped reads, as well as idle cycles, give a zero bus_rdata. Only the bench scenarios can show the rest: the position of each select field, the non-sequential alternate code map, the accumulation of set and clear writes while a pin is not an output, masking of the nonexistent upper pins, and the old-old-new pattern of back-to-back level reads.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int BUS_W         = 32;
  localparam int FN_W          = 3;
  localparam int PINS_PER_SEL  = 10;
  localparam int PINS_PER_BANK = 32;
  localparam int N_ALT         = 6;
  localparam int PULL_W        = 2;

  // word offsets (byte offset / 4)
  localparam int W_SEL  = 0;
  localparam int W_SET  = 7;
  localparam int W_CLR  = 10;
  localparam int W_LEV  = 13;
  localparam int W_PCTL = 37;
  localparam int W_PCLK = 38;

  typedef enum logic [FN_W-1:0] {
    FN_INPUT  = 3'b000,
    FN_OUTPUT = 3'b001,
    FN_ALT5   = 3'b010,
    FN_ALT4   = 3'b011,
    FN_ALT0   = 3'b100,
    FN_ALT1   = 3'b101,
    FN_ALT2   = 3'b110,
    FN_ALT3   = 3'b111
  } fn_e;

  function automatic logic fn_is_alt(input logic [FN_W-1:0] code);
    return code[2] | code[1];
  endfunction

  function automatic logic [2:0] fn_alt_index(input logic [FN_W-1:0] code);
    case (code)
      FN_ALT0: return 3'd0;
      FN_ALT1: return 3'd1;
      FN_ALT2: return 3'd2;
      FN_ALT3: return 3'd3;
      FN_ALT4: return 3'd4;
      FN_ALT5: return 3'd5;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/gpio_mux_fsel.sv
module gpio_mux_fsel
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int WORD_W   = 6,
  localparam int N_SEL   = (NUM_PINS + PINS_PER_SEL - 1) / PINS_PER_SEL
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [WORD_W-1:0]        word,
  input  logic [BUS_W-1:0]         wdata,
  output logic [FN_W*NUM_PINS-1:0] fsel_flat,
  output logic                     sel_hit,
  output logic [BUS_W-1:0]         rd_word
);
  logic [FN_W-1:0] fsel_q [NUM_PINS];
  logic            top_bits_unused;

  assign top_bits_unused = ^wdata[BUS_W-1:FN_W*PINS_PER_SEL];
  assign sel_hit = (int'(word) - W_SEL) < N_SEL;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int REG_IX = p / PINS_PER_SEL;
    localparam int LSB    = FN_W * (p % PINS_PER_SEL);

    always_ff @(posedge clk) begin
      if (!rst_n)
        fsel_q[p] <= FN_INPUT;
      else if (wr_en && int'(word) == W_SEL + REG_IX)
        fsel_q[p] <= wdata[LSB +: FN_W];
    end

    assign fsel_flat[FN_W*p +: FN_W] = fsel_q[p];
  end

  always_comb begin
    rd_word = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (int'(word) == W_SEL + p / PINS_PER_SEL)
        rd_word[FN_W*(p % PINS_PER_SEL) +: FN_W] = fsel_q[p];
    end
  end
endmodule

// File: rtl/gpio_mux_sync.sv
module gpio_mux_sync #(
  parameter int WIDTH  = 54,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_mux_pull.sv
module gpio_mux_pull
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int WORD_W   = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [WORD_W-1:0]          word,
  input  logic [BUS_W-1:0]           wdata,
  output logic [PULL_W-1:0]          ctl_q,
  output logic [NUM_PINS-1:0]        strobe_q,
  output logic [PULL_W*NUM_PINS-1:0] state_flat
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      ctl_q <= '0;
    else if (wr_en && int'(word) == W_PCTL)
      ctl_q <= wdata[PULL_W-1:0];
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int BANK = p / PINS_PER_BANK;
    localparam int BIT  = p % PINS_PER_BANK;
    logic [PULL_W-1:0] st_q;

    always_ff @(posedge clk) begin
      if (!rst_n)
        strobe_q[p] <= 1'b0;
      else if (wr_en && int'(word) == W_PCLK + BANK)
        strobe_q[p] <= wdata[BIT];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        st_q <= '0;
      else if (strobe_q[p])
        st_q <= ctl_q;
    end

    assign state_flat[PULL_W*p +: PULL_W] = st_q;
  end
endmodule

// File: rtl/gpio_mux_pin.sv
module gpio_mux_pin
  import gpio_mux_pkg::*;
(
  input  logic [FN_W-1:0]  fn,
  input  logic             latch,
  input  logic             level,
  input  logic [N_ALT-1:0] alt_oe,
  input  logic [N_ALT-1:0] alt_out,
  output logic             oe,
  output logic             out,
  output logic [N_ALT-1:0] alt_in
);
  logic [2:0] k;

  always_comb begin
    k      = fn_alt_index(fn);
    oe     = 1'b0;
    out    = 1'b0;
    alt_in = '0;
    if (fn == FN_OUTPUT) begin
      oe  = 1'b1;
      out = latch;
    end else if (fn_is_alt(fn)) begin
      oe        = alt_oe[k];
      out       = alt_out[k];
      alt_in[k] = level;
    end
  end
endmodule

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [31:0]               bus_wdata,
  input  logic                      bus_wr_en,
  input  logic                      bus_rd_en,
  output logic [31:0]               bus_rdata,
  input  logic [NUM_PINS-1:0]       pad_in,
  output logic [NUM_PINS-1:0]       pad_oe,
  output logic [NUM_PINS-1:0]       pad_out,
  output logic [2*NUM_PINS-1:0]     pull_state,
  input  logic [6*NUM_PINS-1:0]     alt_oe,
  input  logic [6*NUM_PINS-1:0]     alt_out,
  output logic [6*NUM_PINS-1:0]     alt_in
);
  localparam int WORD_W  = ADDR_W - 2;
  localparam int N_BANKS = (NUM_PINS + PINS_PER_BANK - 1) / PINS_PER_BANK;
  localparam int PAD_W   = N_BANKS * PINS_PER_BANK;

  logic [WORD_W-1:0]          word;
  logic                       addr_lsb_unused;
  logic [FN_W*NUM_PINS-1:0]   fsel_flat;
  logic                       sel_hit;
  logic [BUS_W-1:0]           sel_rd_word;
  logic [NUM_PINS-1:0]        level;
  logic [PAD_W-1:0]           level_pad;
  logic [NUM_PINS-1:0]        lat_q;
  logic [PULL_W-1:0]          pull_ctl;
  logic [NUM_PINS-1:0]        pull_strobe;
  logic [BUS_W-1:0]           rd_mux;

  assign word            = bus_addr[ADDR_W-1:2];
  assign addr_lsb_unused = ^bus_addr[1:0];

  gpio_mux_fsel #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W)) u_fsel (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .word(word), .wdata(bus_wdata),
    .fsel_flat(fsel_flat), .sel_hit(sel_hit), .rd_word(sel_rd_word)
  );

  gpio_mux_sync #(.WIDTH(NUM_PINS), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(level)
  );

  gpio_mux_pull #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W)) u_pull (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .word(word), .wdata(bus_wdata),
    .ctl_q(pull_ctl), .strobe_q(pull_strobe), .state_flat(pull_state)
  );

  assign level_pad = PAD_W'(level);

  // output latches and per-pin routing
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int BANK = p / PINS_PER_BANK;
    localparam int BIT  = p % PINS_PER_BANK;
    logic [N_ALT-1:0] a_oe, a_out, a_in;

    always_ff @(posedge clk) begin
      if (!rst_n)
        lat_q[p] <= 1'b0;
      else if (bus_wr_en && bus_wdata[BIT] && int'(word) == W_SET + BANK)
        lat_q[p] <= 1'b1;
      else if (bus_wr_en && bus_wdata[BIT] && int'(word) == W_CLR + BANK)
        lat_q[p] <= 1'b0;
    end

    for (genvar k = 0; k < N_ALT; k++) begin : g_alt
      assign a_oe[k]                 = alt_oe[k*NUM_PINS + p];
      assign a_out[k]                = alt_out[k*NUM_PINS + p];
      assign alt_in[k*NUM_PINS + p]  = a_in[k];
    end

    gpio_mux_pin u_pin (
      .fn(fsel_flat[FN_W*p +: FN_W]), .latch(lat_q[p]), .level(level[p]),
      .alt_oe(a_oe), .alt_out(a_out),
      .oe(pad_oe[p]), .out(pad_out[p]), .alt_in(a_in)
    );
  end

  // read path
  always_comb begin
    rd_mux = '0;
    if (sel_hit)
      rd_mux = sel_rd_word;
    for (int b = 0; b < N_BANKS; b++) begin
      if (int'(word) == W_LEV + b)
        rd_mux = level_pad[PINS_PER_BANK*b +: PINS_PER_BANK];
    end
    if (int'(word) == W_PCTL)
      rd_mux = {{(BUS_W-PULL_W){1'b0}}, pull_ctl};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      bus_rdata <= '0;
    else
      bus_rdata <= bus_rd_en ? rd_mux : '0;
  end
endmodule

// File: rtl/gpio_mux_ctrl_chk.sv
module gpio_mux_ctrl_chk
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic                     bus_rd_en,
  input logic [31:0]              bus_rdata,
  input logic [NUM_PINS-1:0]      pad_in,
  input logic [NUM_PINS-1:0]      pad_oe,
  input logic [NUM_PINS-1:0]      pad_out,
  input logic [2*NUM_PINS-1:0]    pull_state,
  input logic [FN_W*NUM_PINS-1:0] fsel_flat,
  input logic [NUM_PINS-1:0]      lat_q,
  input logic [NUM_PINS-1:0]      level,
  input logic [PULL_W-1:0]        pull_ctl,
  input logic [NUM_PINS-1:0]      pull_strobe
);
  localparam int N_SEL   = (NUM_PINS + PINS_PER_SEL - 1) / PINS_PER_SEL;
  localparam int N_BANKS = (NUM_PINS + PINS_PER_BANK - 1) / PINS_PER_BANK;

  function automatic logic reads_zero(input logic [ADDR_W-1:0] a);
    int w;
    w = int'(a[ADDR_W-1:2]);
    return !((w >= W_SEL && w < W_SEL + N_SEL) ||
             (w >= W_LEV && w < W_LEV + N_BANKS) || w == W_PCTL);
  endfunction

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) == 1'b0 |-> pad_oe == '0 && pull_state == '0);

  // R7
  level_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n, 2) && $past(rst_n) |-> level == $past(pad_in, 2));

  // R9
  pull_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pull_strobe) == '0 |-> $stable(pull_state));

  // R10
  zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd_en) && reads_zero($past(bus_addr)) |-> bus_rdata == '0);

  // R12
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd_en) |-> bus_rdata == '0);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    // R3
    input_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fsel_flat[FN_W*p +: FN_W] == FN_INPUT |-> !pad_oe[p]);
    // R3
    output_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fsel_flat[FN_W*p +: FN_W] == FN_OUTPUT |-> pad_oe[p] && pad_out[p] == lat_q[p]);
    // R9
    pull_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pull_strobe[p]) |-> pull_state[PULL_W*p +: PULL_W] == $past(pull_ctl));
  end
endmodule

bind gpio_mux_ctrl gpio_mux_ctrl_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd_en(bus_rd_en),
  .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
  .pull_state(pull_state), .fsel_flat(fsel_flat), .lat_q(lat_q), .level(level),
  .pull_ctl(pull_ctl), .pull_strobe(pull_strobe)
);

// File: tb/gpio_mux_ctrl_test.sv
module gpio_mux_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 54;
  localparam int NA = 6 * NP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [31:0] rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_oe, pad_out;
  logic [2*NP-1:0] pull_state;
  logic [NA-1:0] alt_oe = '0, alt_out = '0, alt_in;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [2:0] m_fsel [NP];
  logic       m_lat  [NP];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_mux_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_wr_en(wr), .bus_rd_en(rd), .bus_rdata(rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pull_state(pull_state),
    .alt_oe(alt_oe), .alt_out(alt_out), .alt_in(alt_in)
  );

  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int alt_ix(input logic [2:0] c);
    case (c)
      3'b100: return 0;
      3'b101: return 1;
      3'b110: return 2;
      3'b111: return 3;
      3'b011: return 4;
      3'b010: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic logic [NP-1:0] e_oe();
    logic [NP-1:0] r;
    for (int p = 0; p < NP; p++) begin
      int k = alt_ix(m_fsel[p]);
      r[p] = (m_fsel[p] == 3'b001) ? 1'b1 : (k >= 0) ? alt_oe[k*NP+p] : 1'b0;
    end
    return r;
  endfunction

  function automatic logic [NP-1:0] e_out();
    logic [NP-1:0] r;
    for (int p = 0; p < NP; p++) begin
      int k = alt_ix(m_fsel[p]);
      r[p] = (m_fsel[p] == 3'b001) ? m_lat[p] : (k >= 0) ? alt_out[k*NP+p] : 1'b0;
    end
    return r;
  endfunction

  function automatic logic [NA-1:0] e_alt_in(input logic [NP-1:0] lvl);
    logic [NA-1:0] r = '0;
    for (int p = 0; p < NP; p++) begin
      int k = alt_ix(m_fsel[p]);
      if (k >= 0) r[k*NP+p] = lvl[p];
    end
    return r;
  endfunction

  function automatic logic [31:0] e_sel(input int n);
    logic [31:0] r = '0;
    for (int i = 0; i < 10; i++)
      if (10*n+i < NP) r[3*i +: 3] = m_fsel[10*n+i];
    return r;
  endfunction

  function automatic void mdl_write(input logic [7:0] a, input logic [31:0] d);
    int w = int'(a[7:2]);
    if (w < 6)
      for (int i = 0; i < 10; i++) begin
        if (10*w+i < NP) m_fsel[10*w+i] = d[3*i +: 3];
      end
    if (w == 7 || w == 8 || w == 10 || w == 11)
      for (int i = 0; i < 32; i++) begin
        int p = 32*((w == 8 || w == 11) ? 1 : 0) + i;
        if (p < NP && d[i]) m_lat[p] = (w < 10);
      end
  endfunction

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    mdl_write(a, d);
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rand_alt();
    logic [351:0] t1, t2;
    for (int i = 0; i < 11; i++) begin
      t1[32*i +: 32] = $urandom();
      t2[32*i +: 32] = $urandom();
    end
    alt_oe = t1[NA-1:0];
    alt_out = t2[NA-1:0];
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, r1, r2, r3;
    void'($urandom(32'd2468));
    for (int p = 0; p < NP; p++) begin m_fsel[p] = 3'b000; m_lat[p] = 1'b0; end
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1 reset state
    chk("R1 pad_oe", 512'(pad_oe), 512'(0));
    chk("R1 pad_out", 512'(pad_out), 512'(0));
    chk("R1 pull_state", 512'(pull_state), 512'(0));
    chk("R12 rdata idle", 512'(rdata), 512'(0));
    for (int n = 0; n < 6; n++) begin
      rd_reg(8'(4*n), r);
      chk("R1 select read", 512'(r), 512'(0));
    end

    // R2 / R10 select layout and unused bits
    wr_reg(8'h00, 32'hFFFF_FFFF);
    rd_reg(8'h00, r);
    chk("R10 select bits 31:30", 512'(r), 512'(32'h3FFF_FFFF));
    wr_reg(8'h14, 32'hFFFF_FFFF);
    rd_reg(8'h14, r);
    chk("R10 select pins above 53", 512'(r), 512'(32'h0000_0FFF));
    wr_reg(8'h0C, 32'h1234_5678);
    rd_reg(8'h0C, r);
    chk("R2 select readback", 512'(r), 512'(32'h1234_5678 & 32'h3FFF_FFFF));
    for (int n = 0; n < 6; n++) wr_reg(8'(4*n), 32'h0);

    // R5 set while in input mode, R3 input mode
    wr_reg(8'h1C, 32'h0000_00F0);
    chk("R3 input mode no drive", 512'(pad_oe), 512'(0));
    wr_reg(8'h00, (32'h1 << 12) | (32'h1 << 15) | (32'h1 << 18) | (32'h1 << 21));
    chk("R3 output enable", 512'(pad_oe[9:0]), 512'(10'h0F0));
    chk("R5 latch held across modes", 512'(pad_out[9:0]), 512'(10'h0F0));
    // R6 clear one bit, zeros have no effect
    wr_reg(8'h28, 32'h0000_0020);
    chk("R6 clear bit", 512'(pad_out[9:0]), 512'(10'h0D0));
    wr_reg(8'h1C, 32'h0);
    chk("R5 zero write no effect", 512'(pad_out[9:0]), 512'(10'h0D0));
    rd_reg(8'h1C, r);
    chk("R10 set reads zero", 512'(r), 512'(0));
    rd_reg(8'h2C, r);
    chk("R10 clear reads zero", 512'(r), 512'(0));

    // R11 upper bank
    wr_reg(8'h20, 32'hFFFF_FFFF);
    wr_reg(8'h14, 32'h0000_0249);
    chk("R11 upper bank outputs", 512'(pad_out[53:50]), 512'(4'hF));
    pad_in = '1;
    wait_cyc(3);
    rd_reg(8'h38, r);
    chk("R11 level bank1 masked", 512'(r), 512'(32'h003F_FFFF));
    wr_reg(8'h2C, 32'hFFC0_0000);
    chk("R11 clear pins 54+ ignored", 512'(pad_out[53:50]), 512'(4'hF));

    // R7 back-to-back level reads
    @(negedge clk);
    pad_in = '0; pad_in[0] = 1'b0; addr = 8'h34; rd = 1'b1;
    @(negedge clk); r1 = rdata;
    @(negedge clk); r2 = rdata;
    @(negedge clk); r3 = rdata; rd = 1'b0;
    chk("R7 first read old", 512'(r1), 512'(32'hFFFF_FFFF));
    chk("R7 second read old", 512'(r2), 512'(32'hFFFF_FFFF));
    chk("R7 third read new", 512'(r3), 512'(0));
    @(negedge clk);
    chk("R12 rdata zero after read", 512'(rdata), 512'(0));

    // R4 directed alt code map
    alt_out = '0;
    alt_oe = '0;
    alt_oe[4*NP +: NP] = '1;
    wr_reg(8'h00, 32'hFAC688);
    chk("R4 alt4 is code 011", 512'(pad_oe[7:0]), 512'(8'b0000_1010));
    chk("R4 oe map", 512'(pad_oe), 512'(e_oe()));

    // R4 / R5 / R6 random mix
    for (int it = 0; it < 60; it++) begin
      logic [NP-1:0] pin_v;
      rand_alt();
      pin_v = {$urandom(), $urandom()};
      pad_in = pin_v;
      case ($urandom_range(0, 2))
        0: wr_reg(8'(4*$urandom_range(0, 5)), $urandom());
        1: wr_reg($urandom_range(0, 1) ? 8'h20 : 8'h1C, $urandom());
        default: wr_reg($urandom_range(0, 1) ? 8'h2C : 8'h28, $urandom());
      endcase
      wait_cyc(3);
      chk("R4 pad_oe random", 512'(pad_oe), 512'(e_oe()));
      chk("R5 R6 pad_out random", 512'(pad_out), 512'(e_out()));
      chk("R4 alt_in random", 512'(alt_in), 512'(e_alt_in(pin_v)));
      if (it % 6 == 0) begin
        int n = $urandom_range(0, 5);
        rd_reg(8'(4*n), r);
        chk("R2 select random readback", 512'(r), 512'(e_sel(n)));
        rd_reg(8'h34, r);
        chk("R7 level any mode", 512'(r), 512'(pin_v[31:0]));
      end
    end

    // R8 pull code register
    wr_reg(8'h94, 32'hFFFF_FFFE);
    rd_reg(8'h94, r);
    chk("R8 pull code readback", 512'(r), 512'(32'h2));
    // R9 strobe latching
    wr_reg(8'h98, 32'h0000_0008);
    chk("R9 not yet latched", 512'(pull_state[7:6]), 512'(2'b00));
    @(negedge clk);
    chk("R9 latched pull-up", 512'(pull_state[7:6]), 512'(2'b10));
    wr_reg(8'h98, 32'h0);
    wr_reg(8'h94, 32'h1);
    wait_cyc(3);
    chk("R9 held after strobe low", 512'(pull_state), 512'(108'h0 | (108'h2 << 6)));
    wr_reg(8'h9C, 32'hFFC0_0100);
    wr_reg(8'h9C, 32'h0);
    chk("R9 pin 40 pull-down", 512'(pull_state[81:80]), 512'(2'b01));
    chk("R11 other pins unchanged", 512'(pull_state), 512'((108'h2 << 6) | (108'h1 << 80)));
    rd_reg(8'h98, r);
    chk("R10 strobe reads zero", 512'(r), 512'(0));
    rd_reg(8'h18, r);
    chk("R10 unmapped 0x18", 512'(r), 512'(0));
    rd_reg(8'h60, r);
    chk("R10 unmapped 0x60", 512'(r), 512'(0));

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule